// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire serial control bus. It holds four 8-bit control registers for an audio converter and presents their decoded fields as plain outputs. The bus lines are sampled by a fast system clock. Each line passes through a synchronizer and an edge detector. A START or STOP is recognised whenever SDA moves while SCL is high. The slave pulls SDA low, open-drain style, for its acknowledge bits and for the zero bits of read data.

A master writes a register in three bytes. The first byte is the 7-bit device address 0x32 with a write flag. The second byte is the register number and the third byte is the value. A read sends the device address with the read flag. It returns the register whose number was last accepted in a write. The master acknowledges a byte to get that register again, and a not-acknowledge ends the read.

Top module: `twi_ctrl_slave`

## Requirements
- R1: After reset the register outputs are volume = 0x7F and every other field = 0, and the read pointer selects register 0.
- R2: A START is SDA falling while SCL is high, and it always restarts address reception, including in the middle of a transfer. A STOP is SDA rising while SCL is high. It returns the slave to idle, releases SDA, and discards a partly received byte.
- R3: The first byte after a START is taken MSB first. Its upper seven bits are the device address and bit 0 is the direction (1 = read, 0 = write). The slave acknowledges only address 0x32. For any other address it acknowledges nothing and changes nothing until the next START.
- R4: In a write, the slave acknowledges the device byte, a register number below 4, and one data byte. The data byte is stored into the addressed register.
- R5: A register number of 4 or more is not acknowledged. The data byte that follows it is neither acknowledged nor stored.
- R6: The fields are decoded as follows. Register 0 bits 7:0 are the volume. Register 1 bit 7 is standby, bit 6 is de-emphasis enable and bit 0 is mute. Register 2 bit 5 is frame adjust, bit 4 is clock adjust, bits 3:2 are the interface mode and bits 1:0 are the word length. Register 3 bits 3:0 are the clock setting.
- R7: A read sends, MSB first, the full 8 bits of the register named by the last accepted register number, reserved bits included. A master acknowledge repeats the same register. A master not-acknowledge ends the read with SDA released.
- R8: The slave changes its SDA pull only while SCL is low, apart from the release caused by a START or STOP.
- R9: A repeated START after the register-number byte turns the transfer into a read of that register.
- R10: Any byte after the single data byte of a write is not acknowledged and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = drive SDA low, 0 = release |
| volume_o | output | 8 | Volume setting, both channels |
| mute_o | output | 1 | Mute both channels |
| standby_o | output | 1 | Standby request |
| deemph_o | output | 1 | De-emphasis enable |
| frame_adj_o | output | 1 | Delay frame sync by one bit clock |
| clk_adj_o | output | 1 | Invert the bit clock |
| fmt_mode_o | output | 2 | Serial audio format select |
| word_len_o | output | 2 | Audio word length select |
| clk_cfg_o | output | 4 | Master clock to sample rate setting |

## Verification
The bench targets these corner cases:
- A STOP that lands four bits into the register-number byte. A slave that kept its bit count across the STOP would later store a corrupted value.
- A repeated START used to switch from setting the pointer to reading it back. A slave that ignored the START while busy would treat the device byte as data.
- A foreign address, and a register number of 4. A slave that got either wrong would acknowledge the bytes or overwrite a register.
- A second data byte in one write, which must leave the registers unchanged.
- A read of the same register twice under master acknowledge, followed by a not-acknowledge that must leave SDA released.

// File: rtl/twi_pkg.sv
// Shared constants, state type and reset image for the two-wire register slave.
// Assumes 8-bit registers; the register count may change if the decode in the top follows.
package twi_pkg;
    localparam int REG_W  = 8;
    localparam int N_REGS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,   // ignore bus until START
        ST_DEV,    // shifting device address + direction
        ST_REG,    // shifting register number
        ST_WDAT,   // shifting write data
        ST_SACK,   // slave drives acknowledge bit
        ST_READ,   // slave shifts out read data
        ST_MACK    // master acknowledge slot after a read byte
    } twi_state_e;

    // Power-on value of register idx: volume register starts at 0x7F, the rest at zero.
    function automatic logic [REG_W-1:0] reg_reset_value(input int idx);
        return (idx == 0) ? 8'h7F : 8'h00;
    endfunction
endpackage

// File: rtl/twi_line_sync.sv
// Multi-flop synchronizer with edge detection for one bus line.
// Assumes STAGES >= 2 and an idle-high line; all flops reset to 1.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pad value through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    // Expose the settled level and one-cycle edge pulses.
    always_comb begin
        level_o = chain[STAGES-1];
        rise_o  = chain[STAGES-1] & ~prev;
        fall_o  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/twi_regfile.sv
// Control register bank with one write port and one asynchronous read port.
// Assumes the caller only presents in-range addresses; reset values come from the package.
module twi_regfile
    import twi_pkg::*;
#(
    parameter int NR = N_REGS,
    parameter int W  = REG_W,
    localparam int AW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [W-1:0]    wdata,
    input  logic [AW-1:0]   raddr,
    output logic [W-1:0]    rdata,
    output logic [NR*W-1:0] regs_flat
);
    logic [W-1:0] mem [NR];

    // Build the reset image once from the package function.
    function automatic logic [NR*W-1:0] reset_image();
        logic [NR*W-1:0] img;
        for (int i = 0; i < NR; i++) img[i*W +: W] = W'(reg_reset_value(i));
        return img;
    endfunction
    localparam logic [NR*W-1:0] RESET_IMAGE = reset_image();

    // Load defaults on reset, otherwise update the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) mem[i] <= RESET_IMAGE[i*W +: W];
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    for (genvar g = 0; g < NR; g++) begin : g_flat
        assign regs_flat[g*W +: W] = mem[g];
    end

    // R1: leaving reset presents the default image.
    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_flat == RESET_IMAGE));
endmodule

// File: rtl/twi_ctrl_slave.sv
// Two-wire bus slave owning the control registers of an audio converter.
// Assumes clk is at least ~20x the SCL rate; no clock stretching, no arbitration,
// 7-bit addressing only. SDA is open drain: sda_pull_o = 1 pulls the line low.
module twi_ctrl_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] volume_o,
    output logic       mute_o,
    output logic       standby_o,
    output logic       deemph_o,
    output logic       frame_adj_o,
    output logic       clk_adj_o,
    output logic [1:0] fmt_mode_o,
    output logic [1:0] word_len_o,
    output logic [3:0] clk_cfg_o
);
    localparam int              AW        = $clog2(N_REGS);
    localparam logic [3:0]      BYTE_BITS = 4'd8;
    localparam logic [REG_W-1:0] REG_LIMIT = REG_W'(N_REGS);

    // ---------------- line conditioning ----------------
    logic [1:0] raw, lvl, rise, fall;
    assign raw = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_sync
        twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[l]),
            .level_o(lvl[l]),
            .rise_o (rise[l]),
            .fall_o (fall[l])
        );
    end

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = rise[0];
    assign scl_fall  = fall[0];
    assign start_det = fall[1] & scl_lvl;
    assign stop_det  = rise[1] & scl_lvl;

    // ---------------- protocol state ----------------
    twi_state_e       state, after;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg, txreg;
    logic [AW-1:0]    ptr;
    logic             mack_ok, wr_stb;
    logic [REG_W-1:0] wr_data, rd_data;
    logic [N_REGS*REG_W-1:0] regs_flat;

    // Bus sequencer: shift bytes, decide acknowledges, drive read bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            after      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            ptr        <= '0;
            sda_pull_o <= 1'b0;
            mack_ok    <= 1'b0;
            wr_stb     <= 1'b0;
            wr_data    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state      <= ST_DEV;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_det) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_REG, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == BYTE_BITS) begin
                            bitcnt <= '0;
                            state  <= ST_IDLE;
                            if (state == ST_DEV && shreg[7:1] == DEV_ADDR) begin
                                sda_pull_o <= 1'b1;
                                state      <= ST_SACK;
                                after      <= shreg[0] ? ST_READ : ST_REG;
                            end else if (state == ST_REG && shreg < REG_LIMIT) begin
                                ptr        <= shreg[AW-1:0];
                                sda_pull_o <= 1'b1;
                                state      <= ST_SACK;
                                after      <= ST_WDAT;
                            end else if (state == ST_WDAT) begin
                                wr_stb     <= 1'b1;
                                wr_data    <= shreg;
                                sda_pull_o <= 1'b1;
                                state      <= ST_SACK;
                                after      <= ST_IDLE;
                            end
                        end
                    end
                    ST_SACK: begin
                        if (scl_fall) begin
                            state  <= after;
                            bitcnt <= '0;
                            if (after == ST_READ) begin
                                txreg      <= rd_data;
                                sda_pull_o <= ~rd_data[7];
                            end else begin
                                sda_pull_o <= 1'b0;
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == BYTE_BITS) begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_MACK;
                                bitcnt     <= '0;
                            end else begin
                                sda_pull_o <= ~txreg[6];
                                txreg      <= {txreg[6:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                state      <= ST_READ;
                                txreg      <= rd_data;
                                sda_pull_o <= ~rd_data[7];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    twi_regfile #(.NR(N_REGS), .W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_stb),
        .waddr    (ptr),
        .wdata    (wr_data),
        .raddr    (ptr),
        .rdata    (rd_data),
        .regs_flat(regs_flat)
    );

    // Field decode of the register bank.
    always_comb begin
        volume_o    = regs_flat[0*REG_W +: 8];
        standby_o   = regs_flat[1*REG_W + 7];
        deemph_o    = regs_flat[1*REG_W + 6];
        mute_o      = regs_flat[1*REG_W + 0];
        frame_adj_o = regs_flat[2*REG_W + 5];
        clk_adj_o   = regs_flat[2*REG_W + 4];
        fmt_mode_o  = regs_flat[2*REG_W + 2 +: 2];
        word_len_o  = regs_flat[2*REG_W + 0 +: 2];
        clk_cfg_o   = regs_flat[3*REG_W + 0 +: 4];
    end

    // R2: a STOP leaves the slave idle with SDA released.
    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> (state == ST_IDLE) && !sda_pull_o);

    // R2: a START re-arms address reception from bit zero.
    assert_start_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV) && (bitcnt == 4'd0));

    // R8: the pull only moves while SCL is low, unless a START/STOP just occurred.
    assert_pull_moves_low_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_det) && !$past(stop_det) && $changed(sda_pull_o)) |-> !scl_lvl);

    // R4: every stored data byte is acknowledged in the same cycle.
    assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sda_pull_o);

    // R7: the master's acknowledge slot is never driven by the slave.
    assert_mack_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK) |-> !sda_pull_o);
endmodule

// File: tb/twi_ctrl_slave_tb.sv
// Bench: behavioural bus master plus a register model compared on every idle clock.
module twi_ctrl_slave_tb_top;
    localparam int H = 20;       // SCL half period in system clocks
    localparam int Q = H / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [7:0] volume;
    logic mute, standby, deemph, frame_adj, clk_adj;
    logic [1:0] fmt_mode, word_len;
    logic [3:0] clk_cfg;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line = sda_m & ~sda_pull;

    twi_ctrl_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .volume_o(volume), .mute_o(mute),
        .standby_o(standby), .deemph_o(deemph), .frame_adj_o(frame_adj),
        .clk_adj_o(clk_adj), .fmt_mode_o(fmt_mode), .word_len_o(word_len),
        .clk_cfg_o(clk_cfg)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    bit done     = 1'b0;
    logic [7:0] model [4];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R6/R1: outputs follow the model register image on every idle clock.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk({volume, standby, deemph, mute, frame_adj, clk_adj, fmt_mode, word_len, clk_cfg} ==
                {model[0], model[1][7], model[1][6], model[1][0], model[2][5], model[2][4],
                 model[2][3:2], model[2][1:0], model[3][3:0]},
                "R6 field decode",
                {volume, standby, deemph, mute, frame_adj, clk_adj, fmt_mode, word_len, clk_cfg},
                {model[0], model[1][7], model[1][6], model[1][0], model[2][5], model[2][4],
                 model[2][3:2], model[2][1:0], model[3][3:0]});
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(H);
    endtask

    task automatic send_bit(input logic b);
        w(Q); sda_m = b; w(Q);
        scl_m = 1'b1; w(H);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        w(Q); sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        ack = ~sda_line;
        w(Q);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        w(Q); sda_m = 1'b1; w(Q);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b1; w(Q);
            b[i] = sda_line;
            w(Q);
            scl_m = 1'b0; w(H);
        end
        w(Q);
        sda_m = give_ack ? 1'b0 : 1'b1;
        w(Q);
        scl_m = 1'b1; w(H);
        scl_m = 1'b0; w(Q);
        sda_m = 1'b1;
    endtask

    // Full three-byte write; returns the three acknowledge bits.
    task automatic reg_write(input logic [7:0] dev, input logic [7:0] ra, input logic [7:0] d,
                             output logic [2:0] acks);
        logic a;
        cmp_en = 1'b0;
        bus_start();
        send_byte(dev, a); acks[2] = a;
        send_byte(ra, a);  acks[1] = a;
        send_byte(d, a);   acks[0] = a;
        bus_stop();
        w(4);
    endtask

    task automatic reg_read(input logic give_ack2, output logic [7:0] b1, output logic [7:0] b2,
                            output logic a);
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'h65, a);
        recv_byte(b1, give_ack2);
        if (give_ack2) recv_byte(b2, 1'b0);
        else b2 = 8'h00;
        bus_stop();
        w(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] r1, r2;
        logic a;
        model[0] = 8'h7F; model[1] = 8'h00; model[2] = 8'h00; model[3] = 8'h00;
        w(5);
        rst_n = 1'b1;
        w(3);
        // R1: reset state at the ports.
        chk(volume == 8'h7F, "R1 volume reset", volume, 8'h7F);
        chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
        cmp_en = 1'b1; w(10);

        // R1/R7: read with the reset pointer returns register 0.
        reg_read(1'b0, r1, r2, a);
        chk(a == 1'b1, "R3 read address ack", a, 1);
        chk(r1 == 8'h7F, "R1 R7 read of reset register 0", r1, 8'h7F);
        cmp_en = 1'b1; w(10);

        // R4/R6: write all four registers.
        reg_write(8'h64, 8'h00, 8'hA5, acks); model[0] = 8'hA5;
        chk(acks == 3'b111, "R4 write acks reg0", acks, 7);
        reg_write(8'h64, 8'h01, 8'hC1, acks); model[1] = 8'hC1;
        chk(acks == 3'b111, "R4 write acks reg1", acks, 7);
        reg_write(8'h64, 8'h02, 8'h3B, acks); model[2] = 8'h3B;
        chk(acks == 3'b111, "R4 write acks reg2", acks, 7);
        reg_write(8'h64, 8'h03, 8'hF9, acks); model[3] = 8'hF9;
        chk(acks == 3'b111, "R4 write acks reg3", acks, 7);
        chk(clk_cfg == 4'h9, "R6 clock setting", clk_cfg, 9);
        chk(fmt_mode == 2'b10 && word_len == 2'b11, "R6 mode and length",
            {fmt_mode, word_len}, 4'b1011);
        cmp_en = 1'b1; w(10);

        // R9/R7: set pointer to 2, repeated START, read twice then NACK.
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'h64, a);
        send_byte(8'h02, a);
        chk(a == 1'b1, "R9 pointer byte ack", a, 1);
        bus_start();
        send_byte(8'h65, a);
        chk(a == 1'b1, "R9 read after repeated start ack", a, 1);
        recv_byte(r1, 1'b1);
        recv_byte(r2, 1'b0);
        w(H);
        chk(sda_pull == 1'b0, "R7 released after master nack", sda_pull, 0);
        bus_stop();
        chk(r1 == 8'h3B, "R9 R7 first read byte", r1, 8'h3B);
        chk(r2 == 8'h3B, "R7 repeat after master ack", r2, 8'h3B);
        cmp_en = 1'b1; w(10);

        // R3: foreign address is ignored entirely.
        reg_write(8'h66, 8'h00, 8'h11, acks);
        chk(acks == 3'b000, "R3 foreign address no acks", acks, 0);
        chk(volume == model[0], "R3 foreign write ignored", volume, model[0]);
        cmp_en = 1'b1; w(10);

        // R5: register number 4 is refused with its data.
        reg_write(8'h64, 8'h04, 8'h22, acks);
        chk(acks == 3'b100, "R5 out-of-range register", acks, 4);
        cmp_en = 1'b1; w(10);
        reg_read(1'b0, r1, r2, a);
        chk(r1 == 8'h3B, "R5 pointer kept after refused number", r1, 8'h3B);
        cmp_en = 1'b1; w(10);

        // R10: a second data byte is refused and stores nothing.
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'h64, a);
        send_byte(8'h01, a);
        send_byte(8'h40, a);
        chk(a == 1'b1, "R10 first data ack", a, 1);
        send_byte(8'h81, a);
        chk(a == 1'b0, "R10 extra byte nack", a, 0);
        bus_stop();
        model[1] = 8'h40;
        w(4);
        chk(standby == 1'b0 && deemph == 1'b1 && mute == 1'b0, "R10 R6 reg1 holds first data",
            {standby, deemph, mute}, 3'b010);
        cmp_en = 1'b1; w(10);

        // R2: STOP four bits into the register number, then a clean transfer.
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'h64, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        w(4);
        chk(sda_pull == 1'b0, "R2 stop releases", sda_pull, 0);
        chk(volume == model[0], "R2 aborted write keeps reg0", volume, model[0]);
        reg_write(8'h64, 8'h00, 8'h00, acks); model[0] = 8'h00;
        chk(acks == 3'b111, "R2 transfer after abort", acks, 7);
        chk(volume == 8'h00, "R4 volume zero", volume, 0);
        cmp_en = 1'b1; w(10);

        // R7: readback of reserved bits in register 3.
        reg_write(8'h64, 8'h03, 8'hA6, acks); model[3] = 8'hA6;
        reg_read(1'b0, r1, r2, a);
        chk(r1 == 8'hA6, "R7 reserved bits read back", r1, 8'hA6);
        cmp_en = 1'b1; w(20);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule